// File: doc/BRIEF.md
# Masked Vector Gather with Line Coalescing

This unit loads a 512-bit destination vector from as many as sixteen 32-bit elements. Each element can sit at an unrelated address. A start pulse captures a base address, sixteen per-lane offsets, a sixteen-bit lane mask and the previous contents of the destination. Each lane's byte address is the base plus four times its offset. After setup the unit runs a loop. On each pass it picks the lowest-numbered lane that is still pending and requests the 64-byte memory line holding that element. When the line comes back, every pending lane whose element lies in that line takes its word, and its pending bit is cleared. The loop goes back for another line while any pending bit remains set.

Memory is reached through a single line-read channel with a valid/ready request and a one-cycle response strobe. Only one line is in flight at a time. When the pending set empties, the unit raises a one-cycle completion strobe and presents the merged vector at the same time. Lanes that were masked off at start return their old contents unchanged.

Top module: `vgather_unit`

## Requirements
- R1: A lane's element address is `base_i + 4*offset`, taken modulo 2^32. Its word within the returned line is address bits [5:2]. Line word w occupies `rsp_data_i[32w+31:32w]`, and lane k of the vector occupies bits [32k+31:32k].
- R2: Every line request address has bits [5:0] equal to zero. Its bits [31:6] equal those of the element that caused the request.
- R3: Each request is for the line of the lowest-numbered lane that is still pending.
- R4: One response fills every pending lane whose address bits [31:6] match the requested line, and clears all of those lanes. The number of requests in one gather therefore equals the number of distinct lines among the enabled lanes.
- R5: Lanes whose mask bit is clear at start return the value given on `old_vec_i` at start.
- R6: The loop ends when no lane is pending. `done_o` is then high for exactly one cycle, with the final vector on `result_o`. If the mask is zero at start, `done_o` rises in the cycle after start and no request is made.
- R7: No new line request is made while a response is still owed.
- R8: A request that is not accepted stays valid with the same address until `req_ready_i` is high.
- R9: A start pulse that arrives while the unit is busy is ignored. It does not change the running gather and does not launch another one.
- R10: After reset the unit is idle, with `busy_o`, `req_valid_o` and `done_o` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Starts a gather when the unit is idle |
| base_i | input | 32 | Base byte address |
| offsets_i | input | 512 | Sixteen 32-bit element offsets, lane k at bits [32k+31:32k] |
| mask_i | input | 16 | Lane enables, bit k enables lane k |
| old_vec_i | input | 512 | Previous destination contents |
| busy_o | output | 1 | High from the cycle after start until the done cycle, inclusive |
| req_valid_o | output | 1 | Line read request valid |
| req_ready_i | input | 1 | Memory accepts the request |
| req_addr_o | output | 32 | Line-aligned request address |
| rsp_valid_i | input | 1 | Line data valid for one cycle |
| rsp_data_i | input | 512 | Returned line, word w at bits [32w+31:32w] |
| done_o | output | 1 | One-cycle completion strobe |
| result_o | output | 512 | Merged vector, valid while `done_o` is high |

## Verification
The gather is tried with several lane layouts:
- all sixteen lanes in one line, which separates coalescing from one request per lane;
- every lane in its own line, in ascending and in descending address order, which shows whether the pick follows lane number or address;
- a sparse mask over four shared lines, which exposes mask handling and the preservation of disabled lanes;
- lanes that point at the same element;
- addresses that wrap past the top of the address space;
- an empty mask.

Request stalls and several response latencies check that requests are held and that only one is in flight. A start pulse injected mid-gather must leave the result and the request count untouched.

// File: rtl/vgather_pkg.sv
package vgather_pkg;

   typedef enum logic [1:0] {
      GS_IDLE = 2'd0,
      GS_REQ  = 2'd1,
      GS_WAIT = 2'd2,
      GS_DONE = 2'd3
   } gs_state_e;

   localparam int PICK_SCAN    = 0;
   localparam int PICK_ISOLATE = 1;

endpackage

// File: rtl/vgather_addr_gen.sv
module vgather_addr_gen #(
   parameter int NUM_LANES  = 16,
   parameter int ADDR_W     = 32,
   parameter int SCALE_LOG2 = 2,
   parameter int LOFS_W     = 6,
   parameter int EOFS_W     = 2,
   parameter int WIDX_W     = 4,
   parameter int TAG_W      = 26
) (
   input  logic [ADDR_W-1:0]           base_i,
   input  logic [NUM_LANES*ADDR_W-1:0] offsets_i,
   output logic [NUM_LANES*TAG_W-1:0]  tags_o,
   output logic [NUM_LANES*WIDX_W-1:0] widx_o
);

   logic [NUM_LANES-1:0] unused_low;

   for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
      logic [ADDR_W-1:0] off_w;
      logic [ADDR_W-1:0] addr_w;
      assign off_w  = offsets_i[l*ADDR_W +: ADDR_W];
      assign addr_w = base_i + (off_w << SCALE_LOG2);
      assign tags_o[l*TAG_W +: TAG_W]   = addr_w[ADDR_W-1:LOFS_W];
      assign widx_o[l*WIDX_W +: WIDX_W] = addr_w[LOFS_W-1:EOFS_W];
      assign unused_low[l] = ^addr_w[EOFS_W-1:0];
   end

endmodule

// File: rtl/vgather_pick.sv
module vgather_pick
   import vgather_pkg::*;
#(
   parameter int NUM_LANES  = 16,
   parameter int LIDX_W     = 4,
   parameter int PICK_STYLE = PICK_SCAN
) (
   input  logic [NUM_LANES-1:0] pend_i,
   output logic [LIDX_W-1:0]    sel_o
);

   if (PICK_STYLE == PICK_ISOLATE) begin : g_iso
      logic [NUM_LANES-1:0] iso;
      assign iso = pend_i & (~pend_i + NUM_LANES'(1));
      always_comb begin
         sel_o = '0;
         for (int i = 0; i < NUM_LANES; i++) begin
            if (iso[i]) sel_o = sel_o | LIDX_W'(i);
         end
      end
   end else begin : g_scan
      always_comb begin
         sel_o = '0;
         for (int i = NUM_LANES - 1; i >= 0; i--) begin
            if (pend_i[i]) sel_o = LIDX_W'(i);
         end
      end
   end

endmodule

// File: rtl/vgather_merge.sv
module vgather_merge #(
   parameter int NUM_LANES = 16,
   parameter int ELEM_W    = 32,
   parameter int LINE_W    = 512,
   parameter int WPL       = 16,
   parameter int WIDX_W    = 4,
   parameter int TAG_W     = 26
) (
   input  logic [NUM_LANES-1:0]        pend_i,
   input  logic [NUM_LANES*TAG_W-1:0]  tags_i,
   input  logic [NUM_LANES*WIDX_W-1:0] widx_i,
   input  logic [TAG_W-1:0]            line_tag_i,
   input  logic [LINE_W-1:0]           line_i,
   input  logic [NUM_LANES*ELEM_W-1:0] vec_i,
   output logic [NUM_LANES-1:0]        hit_o,
   output logic [NUM_LANES*ELEM_W-1:0] vec_o
);

   logic [ELEM_W-1:0] words [WPL];

   for (genvar w = 0; w < WPL; w++) begin : g_word
      assign words[w] = line_i[w*ELEM_W +: ELEM_W];
   end

   for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
      logic [TAG_W-1:0]  tag_l;
      logic [WIDX_W-1:0] wi_l;
      assign tag_l    = tags_i[l*TAG_W +: TAG_W];
      assign wi_l     = widx_i[l*WIDX_W +: WIDX_W];
      assign hit_o[l] = pend_i[l] && (tag_l == line_tag_i);
      assign vec_o[l*ELEM_W +: ELEM_W] = hit_o[l] ? words[wi_l]
                                                  : vec_i[l*ELEM_W +: ELEM_W];
   end

endmodule

// File: rtl/vgather_ctrl.sv
module vgather_ctrl
   import vgather_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      start_i,
   input  logic      mask_zero_i,
   input  logic      req_ready_i,
   input  logic      rsp_valid_i,
   input  logic      rest_zero_i,
   output gs_state_e state_o,
   output logic      load_o,
   output logic      issue_o,
   output logic      merge_o
);

   gs_state_e state_q, state_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= GS_IDLE;
      else        state_q <= state_d;
   end

   always_comb begin
      state_d = state_q;
      load_o  = 1'b0;
      issue_o = 1'b0;
      merge_o = 1'b0;
      case (state_q)
         GS_IDLE: begin
            if (start_i) begin
               load_o  = 1'b1;
               state_d = mask_zero_i ? GS_DONE : GS_REQ;
            end
         end
         GS_REQ: begin
            if (req_ready_i) begin
               issue_o = 1'b1;
               state_d = GS_WAIT;
            end
         end
         GS_WAIT: begin
            if (rsp_valid_i) begin
               merge_o = 1'b1;
               state_d = rest_zero_i ? GS_DONE : GS_REQ;
            end
         end
         GS_DONE: state_d = GS_IDLE;
         default: state_d = GS_IDLE;
      endcase
   end

   assign state_o = state_q;

endmodule

// File: rtl/vgather_unit.sv
module vgather_unit
   import vgather_pkg::*;
#(
   parameter int NUM_LANES  = 16,
   parameter int ELEM_W     = 32,
   parameter int ADDR_W     = 32,
   parameter int LINE_BYTES = 64,
   parameter int SCALE_LOG2 = 2,
   parameter int PICK_STYLE = PICK_SCAN,
   localparam int VEC_W     = NUM_LANES * ELEM_W,
   localparam int LINE_W    = LINE_BYTES * 8
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        start_i,
   input  logic [ADDR_W-1:0]           base_i,
   input  logic [NUM_LANES*ADDR_W-1:0] offsets_i,
   input  logic [NUM_LANES-1:0]        mask_i,
   input  logic [VEC_W-1:0]            old_vec_i,
   output logic                        busy_o,
   output logic                        req_valid_o,
   input  logic                        req_ready_i,
   output logic [ADDR_W-1:0]           req_addr_o,
   input  logic                        rsp_valid_i,
   input  logic [LINE_W-1:0]           rsp_data_i,
   output logic                        done_o,
   output logic [VEC_W-1:0]            result_o
);

   localparam int LOFS_W     = $clog2(LINE_BYTES);
   localparam int ELEM_BYTES = ELEM_W / 8;
   localparam int EOFS_W     = $clog2(ELEM_BYTES);
   localparam int WPL        = LINE_BYTES / ELEM_BYTES;
   localparam int WIDX_W     = $clog2(WPL);
   localparam int LIDX_W     = $clog2(NUM_LANES);
   localparam int TAG_W      = ADDR_W - LOFS_W;

   initial begin
      assert (LINE_BYTES == (1 << LOFS_W))
         else $error("line size must be a power of two");
      assert (ELEM_W % 8 == 0 && ELEM_BYTES == (1 << EOFS_W))
         else $error("element width must be a power-of-two byte count");
      assert (WPL >= 2 && LINE_W >= ELEM_W)
         else $error("line must hold at least two elements");
      assert (NUM_LANES >= 2 && NUM_LANES == (1 << LIDX_W))
         else $error("lane count must be a power of two of at least two");
      assert (ADDR_W > LOFS_W)
         else $error("address narrower than line offset");
      assert (PICK_STYLE == PICK_SCAN || PICK_STYLE == PICK_ISOLATE)
         else $error("unknown pick style");
   end

   gs_state_e                  state;
   logic                       load, issue, merge;
   logic [NUM_LANES-1:0]       pend_q;
   logic [NUM_LANES*TAG_W-1:0] tags_q, tags_w;
   logic [NUM_LANES*WIDX_W-1:0] widx_q, widx_w;
   logic [TAG_W-1:0]           line_tag_q, sel_tag;
   logic [VEC_W-1:0]           vec_q, vec_mrg;
   logic [NUM_LANES-1:0]       hit;
   logic [LIDX_W-1:0]          sel;
   logic                       rest_zero;

   vgather_addr_gen #(
      .NUM_LANES (NUM_LANES),
      .ADDR_W    (ADDR_W),
      .SCALE_LOG2(SCALE_LOG2),
      .LOFS_W    (LOFS_W),
      .EOFS_W    (EOFS_W),
      .WIDX_W    (WIDX_W),
      .TAG_W     (TAG_W)
   ) addr_gen_i (
      .base_i   (base_i),
      .offsets_i(offsets_i),
      .tags_o   (tags_w),
      .widx_o   (widx_w)
   );

   vgather_pick #(
      .NUM_LANES (NUM_LANES),
      .LIDX_W    (LIDX_W),
      .PICK_STYLE(PICK_STYLE)
   ) pick_i (
      .pend_i(pend_q),
      .sel_o (sel)
   );

   vgather_merge #(
      .NUM_LANES(NUM_LANES),
      .ELEM_W   (ELEM_W),
      .LINE_W   (LINE_W),
      .WPL      (WPL),
      .WIDX_W   (WIDX_W),
      .TAG_W    (TAG_W)
   ) merge_i (
      .pend_i    (pend_q),
      .tags_i    (tags_q),
      .widx_i    (widx_q),
      .line_tag_i(line_tag_q),
      .line_i    (rsp_data_i),
      .vec_i     (vec_q),
      .hit_o     (hit),
      .vec_o     (vec_mrg)
   );

   assign rest_zero = ~|(pend_q & ~hit);

   vgather_ctrl ctrl_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .start_i    (start_i),
      .mask_zero_i(~|mask_i),
      .req_ready_i(req_ready_i),
      .rsp_valid_i(rsp_valid_i),
      .rest_zero_i(rest_zero),
      .state_o    (state),
      .load_o     (load),
      .issue_o    (issue),
      .merge_o    (merge)
   );

   assign sel_tag = tags_q[sel*TAG_W +: TAG_W];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q     <= '0;
         tags_q     <= '0;
         widx_q     <= '0;
         vec_q      <= '0;
         line_tag_q <= '0;
      end else begin
         if (load) begin
            pend_q <= mask_i;
            tags_q <= tags_w;
            widx_q <= widx_w;
            vec_q  <= old_vec_i;
         end
         if (issue) line_tag_q <= sel_tag;
         if (merge) begin
            pend_q <= pend_q & ~hit;
            vec_q  <= vec_mrg;
         end
      end
   end

   assign busy_o      = (state != GS_IDLE);
   assign req_valid_o = (state == GS_REQ);
   assign req_addr_o  = {sel_tag, {LOFS_W{1'b0}}};
   assign done_o      = (state == GS_DONE);
   assign result_o    = vec_q;

endmodule

// File: rtl/vgather_checker.sv
module vgather_checker #(
   parameter int ADDR_W = 32,
   parameter int LOFS_W = 6
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start_i,
   input logic              busy_o,
   input logic              req_valid_o,
   input logic              req_ready_i,
   input logic [ADDR_W-1:0] req_addr_o,
   input logic              rsp_valid_i,
   input logic              done_o
);

   logic outst_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          outst_q <= 1'b0;
      else if (req_valid_o && req_ready_i) outst_q <= 1'b1;
      else if (rsp_valid_i)                outst_q <= 1'b0;
   end

   AST_LINE_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid_o |-> (req_addr_o[LOFS_W-1:0] == '0)); // R2

   AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid_o |-> !outst_q); // R7

   AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid_o && !req_ready_i) |=> (req_valid_o && $stable(req_addr_o))); // R8

   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o); // R6

   AST_BUSY_FROM_START: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_o) |-> $past(start_i)); // R9

   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o |-> (!req_valid_o && !done_o)); // R10

endmodule

bind vgather_unit vgather_checker #(
   .ADDR_W(ADDR_W),
   .LOFS_W(LOFS_W)
) chk_i (
   .clk        (clk),
   .rst_n      (rst_n),
   .start_i    (start_i),
   .busy_o     (busy_o),
   .req_valid_o(req_valid_o),
   .req_ready_i(req_ready_i),
   .req_addr_o (req_addr_o),
   .rsp_valid_i(rsp_valid_i),
   .done_o     (done_o)
);

// File: tb/vgather_unit_tb_top.sv
module vgather_unit_tb_top;

   localparam int NL = 16;
   localparam int EW = 32;
   localparam int AW = 32;
   localparam int VW = NL * EW;
   localparam int LW = 512;

   typedef logic [31:0] offs_t [NL];

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           start_i = 1'b0;
   logic [AW-1:0]  base_i = '0;
   logic [NL*AW-1:0] offsets_i = '0;
   logic [NL-1:0]  mask_i = '0;
   logic [VW-1:0]  old_vec_i = '0;
   logic           req_ready_i = 1'b0;
   logic           rsp_valid_i = 1'b0;
   logic [LW-1:0]  rsp_data_i = '0;
   logic           busy_o, req_valid_o, done_o;
   logic [AW-1:0]  req_addr_o;
   logic [VW-1:0]  result_o;

   vgather_unit dut_i (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .base_i(base_i),
      .offsets_i(offsets_i), .mask_i(mask_i), .old_vec_i(old_vec_i),
      .busy_o(busy_o), .req_valid_o(req_valid_o), .req_ready_i(req_ready_i),
      .req_addr_o(req_addr_o), .rsp_valid_i(rsp_valid_i), .rsp_data_i(rsp_data_i),
      .done_o(done_o), .result_o(result_o)
   );

   always #4 clk = ~clk;

   int n_chk = 0, n_err = 0;
   int cyc = 0, lat_cfg = 0, lat_left = 0;
   int req_cnt = 0, done_cnt = 0;
   bit stall_mode = 1'b0, pend_rsp = 1'b0, prev_stall = 1'b0, prev_done = 1'b0;
   logic [31:0] pend_addr = '0, prev_addr = '0;
   string cur_req = "R5";

   logic [VW-1:0] exp_vec_q [$];
   logic [31:0]   exp_line_q [$];
   int            exp_nreq_q [$];

   task automatic chk(input bit ok, input string req,
                      input logic [VW-1:0] act, input logic [VW-1:0] exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic finish_up();
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   endtask

   function automatic logic [31:0] mem_word(input logic [31:0] a);
      return (a * 32'h9E37_79B1) ^ 32'hC3A5_5A3C;
   endfunction

   function automatic logic [LW-1:0] line_data(input logic [31:0] la);
      logic [LW-1:0] d;
      for (int w = 0; w < 16; w++) d[w*32 +: 32] = mem_word(la + 32'(w * 4));
      return d;
   endfunction

   function automatic logic [VW-1:0] pattern(input logic [31:0] seed);
      logic [VW-1:0] v;
      for (int i = 0; i < NL; i++) v[i*32 +: 32] = seed ^ (32'(i) * 32'h0101_0101);
      return v;
   endfunction

   // Expected result from the requirements: lowest pending lane picks the line (R3),
   // every pending lane in that line is filled (R4), masked-off lanes keep old data (R5).
   task automatic expect_gather(input logic [31:0] base, input offs_t offs,
                                input logic [NL-1:0] mask, input logic [VW-1:0] old);
      logic [31:0]   a [NL];
      logic [NL-1:0] m;
      logic [VW-1:0] v;
      int            n;
      int            low;
      for (int i = 0; i < NL; i++) a[i] = base + (offs[i] << 2);
      m = mask; v = old; n = 0;
      while (m != '0) begin
         low = -1;
         for (int i = NL - 1; i >= 0; i--) if (m[i]) low = i;
         exp_line_q.push_back({a[low][31:6], 6'b0});
         n++;
         for (int j = 0; j < NL; j++) begin
            if (m[j] && a[j][31:6] == a[low][31:6]) begin
               v[j*32 +: 32] = mem_word({a[j][31:2], 2'b00});
               m[j] = 1'b0;
            end
         end
      end
      exp_vec_q.push_back(v);
      exp_nreq_q.push_back(n);
   endtask

   task automatic drive_start(input logic [31:0] base, input offs_t offs,
                              input logic [NL-1:0] mask, input logic [VW-1:0] old);
      @(negedge clk);
      base_i = base; mask_i = mask; old_vec_i = old;
      for (int i = 0; i < NL; i++) offsets_i[i*32 +: 32] = offs[i];
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
   endtask

   task automatic run(input logic [31:0] base, input offs_t offs, input logic [NL-1:0] mask,
                      input logic [VW-1:0] old, input string req);
      int d0;
      d0 = done_cnt;
      cur_req = req;
      expect_gather(base, offs, mask, old);
      drive_start(base, offs, mask, old);
      if (mask == '0) chk(done_o == 1'b1, "R6 empty-mask done timing", VW'(done_o), VW'(1));
      wait (done_cnt != d0);
      @(negedge clk);
   endtask

   // Responder, request scoreboard and result monitor.
   initial begin
      logic [31:0]   e_line;
      logic [VW-1:0] e_vec;
      int            e_n;
      forever begin
         @(negedge clk);
         cyc++;
         if (rst_n) begin
            rsp_valid_i = 1'b0;
            if (pend_rsp) begin
               if (lat_left == 0) begin
                  rsp_valid_i = 1'b1;
                  rsp_data_i  = line_data(pend_addr);
                  pend_rsp    = 1'b0;
               end else lat_left--;
            end
            req_ready_i = stall_mode ? (cyc % 3 == 0) : 1'b1;
            if (prev_stall)
               chk(req_valid_o && req_addr_o == prev_addr, "R8 held request",
                   VW'({req_valid_o, req_addr_o}), VW'({1'b1, prev_addr}));
            prev_stall = req_valid_o && !req_ready_i;
            prev_addr  = req_addr_o;
            if (req_valid_o && req_ready_i) begin
               chk(!pend_rsp, "R7 request while response owed", VW'(pend_rsp), VW'(0));
               chk(req_addr_o[5:0] == 6'd0, "R2 line alignment", VW'(req_addr_o[5:0]), VW'(0));
               if (exp_line_q.size() == 0) begin
                  chk(1'b0, "R4 extra request", VW'(req_addr_o), VW'(0));
               end else begin
                  e_line = exp_line_q.pop_front();
                  chk(req_addr_o == e_line, "R3 request order", VW'(req_addr_o), VW'(e_line));
               end
               pend_rsp  = 1'b1;
               lat_left  = lat_cfg;
               pend_addr = req_addr_o;
               req_cnt++;
            end
            if (done_o) begin
               chk(!prev_done, "R6 done width", VW'(prev_done), VW'(0));
               if (!prev_done) begin
                  if (exp_vec_q.size() == 0) begin
                     chk(1'b0, "R6 unexpected done", result_o, '0);
                  end else begin
                     e_vec = exp_vec_q.pop_front();
                     e_n   = exp_nreq_q.pop_front();
                     chk(result_o == e_vec, cur_req, result_o, e_vec);
                     chk(req_cnt == e_n, "R4 line count", VW'(req_cnt), VW'(e_n));
                  end
                  req_cnt = 0;
                  done_cnt++;
               end
            end
            prev_done = done_o;
         end
      end
   end

   initial begin
      #(8 * 150000);
      n_chk++; n_err++;
      $display("FAIL watchdog R6 actual=hung expected=done");
      finish_up();
   end

   initial begin
      offs_t o;
      int    d0;
      repeat (3) @(negedge clk);
      chk(!busy_o && !req_valid_o && !done_o, "R10 reset state",
          VW'({busy_o, req_valid_o, done_o}), VW'(0));
      rst_n = 1'b1;
      @(negedge clk);

      // one line holds all lanes: a single request (R4)
      for (int i = 0; i < NL; i++) o[i] = 32'(15 - i);
      run(32'h0000_1000, o, 16'hFFFF, pattern(32'h1111_0000), "R4 one line");

      // each lane in its own ascending line (R3)
      for (int i = 0; i < NL; i++) o[i] = 32'(i * 16 + 3);
      run(32'h0002_0040, o, 16'hFFFF, pattern(32'h2222_0000), "R3 ascending lines");

      // descending addresses: still lowest lane first (R3)
      lat_cfg = 2;
      for (int i = 0; i < NL; i++) o[i] = 32'((15 - i) * 16 + 1);
      run(32'h0003_0000, o, 16'hFFFF, pattern(32'h3333_0000), "R3 descending lines");

      // sparse mask over four shared lines (R5)
      for (int i = 0; i < NL; i++) o[i] = 32'((i % 4) * 16 + i);
      run(32'h0004_0000, o, 16'hA5C3, pattern(32'h4444_0000), "R5 sparse mask");

      // empty mask (R6)
      run(32'h0005_0000, o, 16'h0000, pattern(32'h5555_0000), "R6 empty mask");

      // wrap past the top of the address space (R1)
      lat_cfg = 0;
      for (int i = 0; i < NL; i++) o[i] = 32'(i * 5);
      run(32'hFFFF_FF80, o, 16'hFFFF, pattern(32'h6666_0000), "R1 address wrap");

      // large offsets that wrap when scaled (R1)
      for (int i = 0; i < NL; i++) o[i] = 32'h4000_0000 + 32'(i * 9);
      run(32'h0000_0100, o, 16'h7FFE, pattern(32'h6767_0000), "R1 scaled offset");

      // duplicate element addresses (R4)
      for (int i = 0; i < NL; i++) o[i] = (i == 5) ? 32'd100 : 32'd7;
      run(32'h0007_0000, o, 16'hFFFF, pattern(32'h7777_0000), "R4 duplicates");

      // request stalls with latency (R8)
      stall_mode = 1'b1; lat_cfg = 1;
      for (int i = 0; i < NL; i++) o[i] = 32'(i * 24);
      run(32'h0008_0000, o, 16'h3CF1, pattern(32'h8888_0000), "R8 stalled gather");
      stall_mode = 1'b0;

      // start while busy is ignored (R9)
      lat_cfg = 4;
      for (int i = 0; i < NL; i++) o[i] = 32'((i % 4) * 32);
      d0 = done_cnt;
      cur_req = "R9 result with mid-run start";
      expect_gather(32'h0009_0000, o, 16'hFFFF, pattern(32'h9999_0000));
      drive_start(32'h0009_0000, o, 16'hFFFF, pattern(32'h9999_0000));
      @(negedge clk);
      @(negedge clk);
      base_i = 32'h000A_0000; mask_i = 16'hFFFF; old_vec_i = '0;
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      wait (done_cnt != d0);
      repeat (4) @(negedge clk);
      chk(!busy_o && req_cnt == 0, "R9 no second gather",
          VW'({busy_o, 32'(req_cnt)}), VW'(0));
      lat_cfg = 0;

      chk(exp_vec_q.size() == 0 && exp_line_q.size() == 0, "R6 all gathers completed",
          VW'(exp_vec_q.size() + exp_line_q.size()), VW'(0));
      finish_up();
   end

endmodule